// File: doc/BRIEF.md
# Pin Bank with Masked Output Updates

This block is one bank of general-purpose pins behind a plain register port. For each pin it stores an output level, a direction bit and a drive-enable bit. It drives the pad output and pad enable lines from them, and it brings the pad levels back in through a two-stage synchronizer. Software can change single output pins without a read-modify-write sequence. It writes a word to one of two half-word update registers. Each such word carries a 16-bit keep mask above 16 bits of new data.

The number of implemented pins is the parameter `PINS`, from 1 to 32. Register bits at or above `PINS` are dropped on write and return 0 on read. Register access is a single-cycle request: `bus_valid` with `bus_write` high writes `bus_wdata` at the rising edge. `bus_valid` with `bus_write` low loads the addressed value into `bus_rdata` at that edge.

Top module: `pinbank_top`

## Requirements
- R1: While `rst` is high and after it falls, all output, direction and drive-enable bits are 0, so `pad_oe` and `pad_out` are 0 and every register reads 0.
- R2: A write to offset 0x000 updates pins 0..15. Word bits 31:16 are a keep mask and bits 15:0 are data. An output bit takes its data bit where the mask bit is 0 and keeps its value where the mask bit is 1.
- R3: A write to offset 0x004 updates pins 16..31 with the same mask rule, where word bit 0 (and mask bit 16) maps to pin 16.
- R4: A write to offset 0x040 replaces all output bits, and a read of 0x040 returns all output bits.
- R5: Offsets 0x204 (direction, 1 = output) and 0x208 (drive enable) are read/write. `pad_oe[i]` is 1 only when both bits of pin i are 1, and `pad_out` follows the output bits.
- R6: A read of offset 0x060 returns the pad levels after a two-flop synchronizer, whatever the direction bits hold. A pad change made just after clock edge k appears in a read request sampled at edge k+3 or later. Writes to 0x060 change nothing.
- R7: A read of 0x000 or 0x004 returns the output bits of that half in bits 15:0 and 0 in bits 31:16.
- R8: Bits at or above `PINS` are ignored on every write and read as 0 in every register.
- R9: Writes to any other offset change no register or pad. Reads of any other offset return 0. Only writes change `pad_out` or `pad_oe`.
- R10: `bus_rdata` changes only at an edge where a read request is present, and it holds the value addressed by that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register request present this cycle |
| bus_write | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | PINS | Pad levels, asynchronous |
| pad_out | output | PINS | Output level per pin |
| pad_oe | output | PINS | Pad drive enable per pin |

## Verification
The stability checks on `pad_out`, `pad_oe` and `bus_rdata` compare against the previous cycle. They therefore assume that reset is held for at least one edge before any request and that `bus_valid` stays low during reset. The bench holds reset for several cycles with the bus idle. It changes the request signals and `pad_in` only on the falling clock edge, so every request is seen as whole at one rising edge. Random pad levels are held for at least three cycles before the input register is read, which keeps the expected value clear of the synchronizer latency.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_UPD_LO = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_UPD_HI = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_LEVELS = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_DRIVE  = 12'h208;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_UPD_LO,
        SEL_UPD_HI,
        SEL_LEVELS,
        SEL_SENSE,
        SEL_DIR,
        SEL_DRIVE
    } reg_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] keep;
        logic [HALF_W-1:0] val;
    } upd_word_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_UPD_LO: return SEL_UPD_LO;
            OFS_UPD_HI: return SEL_UPD_HI;
            OFS_LEVELS: return SEL_LEVELS;
            OFS_SENSE:  return SEL_SENSE;
            OFS_DIR:    return SEL_DIR;
            OFS_DRIVE:  return SEL_DRIVE;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] cur,
                                                     input upd_word_t w);
        return (cur & w.keep) | (w.val & ~w.keep);
    endfunction

    function automatic logic [BUS_W-1:0] pin_mask(input int unsigned n);
        if (n >= BUS_W) return '1;
        return (32'h1 << n) - 32'h1;
    endfunction

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    assign sel = decode_offset(addr);
endmodule

// File: rtl/pinbank_insync.sv
module pinbank_insync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_a;
    logic [WIDTH-1:0] stage_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= '0;
            stage_b <= '0;
        end else begin
            stage_a <= async_in;
            stage_b <= stage_a;
        end
    end

    assign sync_out = stage_b;

    // R6: the visible level is the pad level seen two edges earlier
    assert_two_stage_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 |-> stage_b == $past(stage_a))
        else $error("synchronizer skipped a stage");
endmodule

// File: rtl/pinbank_ctrlregs.sv
module pinbank_ctrlregs
    import pinbank_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] out_q,
    output logic [BUS_W-1:0] dir_q,
    output logic [BUS_W-1:0] drv_q
);
    localparam logic [BUS_W-1:0] IMPL = pin_mask(PINS);
    localparam int unsigned NHALF = BUS_W / HALF_W;

    logic [NHALF-1:0] half_hit;
    logic [BUS_W-1:0] half_nx;
    logic [BUS_W-1:0] out_d;
    logic [BUS_W-1:0] dir_d;
    logic [BUS_W-1:0] drv_d;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam reg_sel_e MY_SEL = (h == 0) ? SEL_UPD_LO : SEL_UPD_HI;
        logic [HALF_W-1:0] merged;

        assign merged      = merge_half(out_q[h*HALF_W +: HALF_W], upd_word_t'(wdata));
        assign half_hit[h] = wr_en && (sel == MY_SEL);
        assign half_nx[h*HALF_W +: HALF_W] = half_hit[h] ? merged
                                                         : out_q[h*HALF_W +: HALF_W];

        // R2 / R3: kept bits do not move, released bits take the new data
        assert_half_keep_R2_R3: assert property (@(posedge clk) disable iff (rst)
            half_hit[h] |=> ((out_q[h*HALF_W +: HALF_W] ^ $past(out_q[h*HALF_W +: HALF_W]))
                             & $past(wdata[BUS_W-1:HALF_W])) == '0)
            else $error("masked bit changed");
        assert_half_load_R2_R3: assert property (@(posedge clk) disable iff (rst)
            half_hit[h] |=> ((out_q[h*HALF_W +: HALF_W] ^ $past(wdata[HALF_W-1:0]))
                             & ~$past(wdata[BUS_W-1:HALF_W])
                             & IMPL[h*HALF_W +: HALF_W]) == '0)
            else $error("released bit did not load");
    end

    always_comb begin
        out_d = (wr_en && sel == SEL_LEVELS) ? wdata : half_nx;
        dir_d = (wr_en && sel == SEL_DIR)    ? wdata : dir_q;
        drv_d = (wr_en && sel == SEL_DRIVE)  ? wdata : drv_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
            drv_q <= '0;
        end else begin
            out_q <= out_d & IMPL;
            dir_q <= dir_d & IMPL;
            drv_q <= drv_d & IMPL;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (out_q == '0 && dir_q == '0 && drv_q == '0))
        else $error("state not cleared by reset");

    assert_full_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_LEVELS) |=> out_q == ($past(wdata) & IMPL))
        else $error("full data write lost");

    assert_no_upper_bits_R8: assert property (@(posedge clk) disable iff (rst)
        ((out_q | dir_q | drv_q) & ~IMPL) == '0)
        else $error("unimplemented bit set");
endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_oe
);
    reg_sel_e         sel;
    logic [BUS_W-1:0] out_q;
    logic [BUS_W-1:0] dir_q;
    logic [BUS_W-1:0] drv_q;
    logic [PINS-1:0]  sensed;
    logic [BUS_W-1:0] sensed_wide;
    logic [BUS_W-1:0] rd_mux;

    pinbank_decode u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    pinbank_ctrlregs #(.PINS(PINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_valid && bus_write),
        .sel   (sel),
        .wdata (bus_wdata),
        .out_q (out_q),
        .dir_q (dir_q),
        .drv_q (drv_q)
    );

    pinbank_insync #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (sensed)
    );

    always_comb begin
        sensed_wide = '0;
        sensed_wide[PINS-1:0] = sensed;
    end

    always_comb begin
        case (sel)
            SEL_UPD_LO: rd_mux = {{HALF_W{1'b0}}, out_q[HALF_W-1:0]};
            SEL_UPD_HI: rd_mux = {{HALF_W{1'b0}}, out_q[BUS_W-1:HALF_W]};
            SEL_LEVELS: rd_mux = out_q;
            SEL_SENSE:  rd_mux = sensed_wide;
            SEL_DIR:    rd_mux = dir_q;
            SEL_DRIVE:  rd_mux = drv_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                          bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end

    assign pad_out = out_q[PINS-1:0];
    assign pad_oe  = dir_q[PINS-1:0] & drv_q[PINS-1:0];

    assert_pads_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid && bus_write) |-> ($stable(pad_out) && $stable(pad_oe)))
        else $error("pads moved without a write");

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid && !bus_write) |-> $stable(bus_rdata))
        else $error("read data moved without a read");
endmodule

// File: tb/tb_pinbank_top.sv
`timescale 1ns/100ps
module tb_pinbank_top;
    localparam int unsigned NP = 26;
    localparam logic [31:0] IMPL = 32'h03FF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [11:0]   bus_addr  = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_out = '0, m_dir = '0, m_drv = '0;
    logic [NP-1:0] m_in = '0;

    always #2.5 clk = ~clk;

    pinbank_top #(.PINS(NP)) dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h000: m_out[15:0]  = (m_out[15:0]  & d[31:16]) | (d[15:0] & ~d[31:16]);
            12'h004: m_out[31:16] = (m_out[31:16] & d[31:16]) | (d[15:0] & ~d[31:16]);
            12'h040: m_out = d;
            12'h204: m_dir = d;
            12'h208: m_drv = d;
            default: ;
        endcase
        m_out &= IMPL; m_dir &= IMPL; m_drv &= IMPL;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h000: return {16'h0, m_out[15:0]};
            12'h004: return {16'h0, m_out[31:16]};
            12'h040: return m_out;
            12'h060: return 32'(m_in);
            12'h204: return m_dir;
            12'h208: return m_drv;
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, d, model_read(a));
    endtask

    task automatic pads_chk(input string req);
        chk(req, 32'(pad_out), m_out);
        chk(req, 32'(pad_oe), m_dir & m_drv);
    endtask

    task automatic set_pads(input logic [NP-1:0] v);
        pad_in = v;
        m_in = v;
        idle(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d, held;
        logic [11:0] addrs [8];
        addrs = '{12'h000, 12'h004, 12'h040, 12'h060, 12'h204, 12'h208, 12'h100, 12'h002};
        void'($urandom(32'd20240611));

        @(negedge clk);
        idle(4);
        // R1: reset state
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 pad_oe",  32'(pad_oe),  32'h0);
        rst = 1'b0;
        idle(1);
        rd_chk("R1 levels", 12'h040);
        rd_chk("R1 dir",    12'h204);
        rd_chk("R1 drive",  12'h208);

        // R2: lower masked write, only pin 0 released
        bus_wr(12'h000, 32'hFFFE_FFFF);
        chk("R2 pin0 only", 32'(pad_out), 32'h0000_0001);
        bus_wr(12'h000, 32'h00F0_A5A5);
        pads_chk("R2 partial mask");
        // R3: upper half bit 0 maps to pin 16
        bus_wr(12'h004, 32'hFFFE_0001);
        chk("R3 pin16", 32'(pad_out) & 32'hFFFF_0000, 32'h0001_0000);
        // R8: upper bits beyond pin 25 dropped
        bus_wr(12'h004, 32'h0000_FFFF);
        rd_chk("R8 upper half read", 12'h004);
        chk("R8 upper half value", model_read(12'h004), 32'h0000_03FF);
        // R4: full replace
        bus_wr(12'h040, 32'hFFFF_FFFF);
        rd_chk("R4 R8 full write", 12'h040);
        bus_wr(12'h040, 32'h0123_4567);
        rd_chk("R4 full read", 12'h040);
        // R7: half reads
        rd_chk("R7 lower half", 12'h000);
        rd_chk("R7 upper half", 12'h004);
        // R5: direction and drive gating
        bus_wr(12'h204, 32'h0000_00FF);
        bus_wr(12'h208, 32'hFFFF_0F0F);
        chk("R5 gate", 32'(pad_oe), 32'h0000_000F);
        rd_chk("R5 R8 drive read", 12'h208);
        rd_chk("R5 dir read", 12'h204);
        // R6: sensed levels regardless of direction, writes ignored
        set_pads(26'h2AB_CDEF);
        rd_chk("R6 sense", 12'h060);
        bus_wr(12'h060, 32'hFFFF_FFFF);
        rd_chk("R6 write ignored", 12'h060);
        pads_chk("R6 R9 write to sense");
        // R9: unmapped offsets
        bus_wr(12'h100, 32'hFFFF_FFFF);
        bus_wr(12'h002, 32'h0000_FFFF);
        pads_chk("R9 unmapped write");
        rd_chk("R9 unmapped read", 12'h100);
        rd_chk("R9 levels untouched", 12'h040);
        // R10: read data holds across writes and idle cycles
        bus_rd(12'h040, held);
        bus_wr(12'h040, 32'h00AA_0055);
        idle(3);
        chk("R10 hold", bus_rdata, held);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            a = addrs[$urandom_range(0, 7)];
            if ($urandom_range(0, 9) == 0) set_pads(NP'($urandom));
            if ($urandom_range(0, 1) == 1) begin
                bus_wr(a, $urandom);
                pads_chk("R2 R3 R5 random write");
            end else begin
                rd_chk("R4 R6 R7 random read", a);
                pads_chk("R9 random read");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule